// File: doc/BRIEF.md
# PHY Control-Bus Handshake Master

This block drives a PHY's parallel control-register bus on behalf of a host. The host presents a command made of an address, write data, a read/write select and a one-cycle start pulse. The block then runs the command as a sequence of strobe handshakes on the bus and reports the outcome.

The bus has one shared data-in bus and four strobes: address capture, data capture, read and write. It also has one acknowledge input and a data-out bus. Each strobe completes a full four-phase exchange with the acknowledge. The strobe rises, the block waits for the acknowledge to rise, the strobe falls, and the block waits for the acknowledge to fall.

Every access starts with an address capture. A read then runs a read-strobe handshake and keeps the data-out value it sees while the acknowledge is high. A write runs a data-capture handshake and then a write-strobe handshake.

Each of the eight possible waits is bounded by a programmable cycle count. When a wait runs out, the block does not stop the command. It marks the command as failed and moves on to the next step.

The acknowledge comes from an unrelated clock domain, so it passes through a multi-flop synchronizer before the sequencer uses it. The host sees a busy level while a command runs and a one-cycle done pulse when it ends. At that point the read data and the error flag are valid.

Top module: `phyctl_hs_master`

## Requirements
- R1: After reset, busy, done, the error flag and all four strobes are low, and the read data is zero.
- R2: Every command begins with an address-capture handshake. While the address strobe is high, the data-in bus carries the command address, zero-extended to the data width.
- R3: A read follows the address handshake with one read-strobe handshake. The read data returned equals the data-out value present while the synchronized acknowledge is high.
- R4: A write follows the address handshake with a data-capture handshake carrying the write data, then a write-strobe handshake. The strobes rise in the order address, data, write.
- R5: At most one strobe is high at any time. The data-in bus is stable in the cycle a strobe rises and for as long as the strobe stays high.
- R6: A strobe stays high until the synchronized acknowledge is seen high or its wait runs out. The next strobe does not rise until the acknowledge is seen low or that wait runs out.
- R7: Each wait lasts at most the programmed number of cycles (cfg_wait_limit). When a wait runs out, the command still continues to its end and the error flag is set. A limit of zero makes every wait that does not see its acknowledge at once fail.
- R8: The error flag is cleared when a command is accepted. It stays set until the next accepted command.
- R9: Busy rises in the cycle after a start is accepted in idle. Done is high for exactly one cycle at the end, with busy still high, and busy is low in the following cycle.
- R10: A start pulse while busy is high is ignored. It causes no extra handshakes, no extra done pulse and no change to the running command.
- R11: The acknowledge passes through SYNC_STAGES flops (at least two). A strobe falls on the (SYNC_STAGES+1)-th rising clock edge after the acknowledge rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle command request, taken only when idle |
| cmd_write | input | 1 | 1 selects write, 0 selects read |
| cmd_addr | input | ADDR_W | Register address on the PHY bus |
| cmd_wdata | input | DATA_W | Write data |
| cfg_wait_limit | input | WAIT_W | Cycle limit for each acknowledge wait |
| busy | output | 1 | High while a command runs |
| done | output | 1 | One-cycle pulse at command end |
| rd_data | output | DATA_W | Data captured by the last read |
| cmd_err | output | 1 | At least one wait of the last command ran out |
| bus_din | output | DATA_W | Shared data-in bus to the PHY |
| stb_addr | output | 1 | Address capture strobe |
| stb_data | output | 1 | Data capture strobe |
| stb_rd | output | 1 | Read strobe |
| stb_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Acknowledge from the PHY, asynchronous |
| bus_dout | input | DATA_W | Read data from the PHY, stable while the acknowledge is high |

## Verification
The bench builds the block with SYNC_STAGES set to 3 and WAIT_W set to 8. The deeper synchronizer makes the edge count from acknowledge to strobe fall differ from the minimum two-flop case, so a synchronizer depth that ignores the parameter is caught. The narrow wait counter keeps the limit small enough that the bench can run a silent PHY into every wait and still see each command finish. A limit of zero shows the immediate-expiry corner. A PHY model with varied response delays checks the strobe order, the data landing at the right address and the read data returned.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

   // Sequencer phase within one strobe handshake
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_RISE  = 3'd2,
      PH_FALL  = 3'd3,
      PH_END   = 3'd4
   } hs_phase_e;

   // Handshake step; value is the strobe index it raises
   typedef enum logic [1:0] {
      STEP_ADDR  = 2'd0,
      STEP_DATA  = 2'd1,
      STEP_READ  = 2'd2,
      STEP_WRITE = 2'd3
   } hs_step_e;

   localparam int unsigned NUM_STROBES = 4;

   // Step that follows a completed handshake; STEP_ADDR means "no more"
   function automatic hs_step_e follow_step(input hs_step_e cur, input logic is_wr);
      hs_step_e nxt;
      unique case (cur)
         STEP_ADDR: nxt = is_wr ? STEP_DATA : STEP_READ;
         STEP_DATA: nxt = STEP_WRITE;
         default:   nxt = STEP_ADDR;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/phyctl_sync.sv
module phyctl_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("phyctl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_async;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/phyctl_wait_tmr.sv
module phyctl_wait_tmr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("phyctl_wait_tmr: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (clr)                      cnt_q <= '0;
      else if (run && (cnt_q < limit))   cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q >= limit);

   // R7
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(clr) && $stable(limit) && ($past(cnt_q) <= $past(limit)))
         |-> (cnt_q <= limit));

   // R7
   expire_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(expired) && !$past(clr) && run && $stable(limit)) |-> expired);

endmodule

// File: rtl/phyctl_seq.sv
module phyctl_seq
   import phyctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   is_write,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic                   ack_s,
   input  logic [DATA_W-1:0]      dout,
   input  logic                   expired,
   output logic [DATA_W-1:0]      din,
   output logic [NUM_STROBES-1:0] stb,
   output logic                   busy,
   output logic                   done,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   err,
   output logic                   tmr_clr,
   output logic                   tmr_run
);

   hs_phase_e             phase_q, phase_d;
   hs_step_e              step_q,  step_d;
   logic                  wr_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     wdata_q;
   logic [DATA_W-1:0]     din_q,   din_d;
   logic [NUM_STROBES-1:0] stb_q,  stb_d;
   logic [DATA_W-1:0]     rd_q;
   logic                  err_q;
   logic                  accept;
   logic                  rise_ok, fall_ok;
   logic                  rise_miss, fall_miss;
   hs_step_e              step_after;

   assign accept     = (phase_q == PH_IDLE) && start;
   assign rise_ok    = (phase_q == PH_RISE) && ack_s;
   assign fall_ok    = (phase_q == PH_FALL) && !ack_s;
   assign rise_miss  = (phase_q == PH_RISE) && !ack_s && expired;
   assign fall_miss  = (phase_q == PH_FALL) && ack_s && expired;
   assign step_after = follow_step(step_q, wr_q);

   // Phase and step sequencing
   always_comb begin
      phase_d = phase_q;
      step_d  = step_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_d = PH_SETUP;
               step_d  = STEP_ADDR;
            end
         end
         PH_SETUP: phase_d = PH_RISE;
         PH_RISE: begin
            if (rise_ok || rise_miss) phase_d = PH_FALL;
         end
         PH_FALL: begin
            if (fall_ok || fall_miss) begin
               if (step_after == STEP_ADDR) begin
                  phase_d = PH_END;
               end else begin
                  phase_d = PH_SETUP;
                  step_d  = step_after;
               end
            end
         end
         PH_END:  phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   // Data-in value prepared on entry to a setup phase
   always_comb begin
      din_d = din_q;
      if (phase_d == PH_SETUP && phase_q != PH_SETUP) begin
         unique case (step_d)
            STEP_ADDR: din_d = DATA_W'(addr);
            STEP_DATA: din_d = wdata_q;
            default:   din_d = '0;
         endcase
      end
   end

   // Strobe for the next cycle: only the current step's strobe, only in RISE
   always_comb begin
      stb_d = '0;
      if (phase_d == PH_RISE) stb_d[step_d] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= STEP_ADDR;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         din_q   <= '0;
         stb_q   <= '0;
         rd_q    <= '0;
         err_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         step_q  <= step_d;
         din_q   <= din_d;
         stb_q   <= stb_d;
         if (accept) begin
            wr_q    <= is_write;
            addr_q  <= addr;
            wdata_q <= wdata;
            err_q   <= 1'b0;
         end else if (rise_miss || fall_miss) begin
            err_q   <= 1'b1;
         end
         if ((phase_q == PH_RISE) && (step_q == STEP_READ) && (ack_s || expired))
            rd_q <= dout;
      end
   end

   assign din     = din_q;
   assign stb     = stb_q;
   assign busy    = (phase_q != PH_IDLE);
   assign done    = (phase_q == PH_END);
   assign rd_data = rd_q;
   assign err     = err_q;
   assign tmr_clr = (phase_d != phase_q);
   assign tmr_run = (phase_q == PH_RISE) || (phase_q == PH_FALL);

   // R5
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_q));

   // R5
   setup_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|stb_q) |-> $stable(din_q));

   // R2
   din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|stb_q) && $past(|stb_q)) |-> $stable(din_q));

   // R6
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|stb_q) && !ack_s && !expired) |=> (stb_q == $past(stb_q)));

   // R6
   no_rise_while_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_FALL) && ack_s && !expired) |=> (stb_q == '0));

   // R7
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(expired));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R10
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));

endmodule

// File: rtl/phyctl_hs_master.sv
module phyctl_hs_master
   import phyctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned WAIT_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [WAIT_W-1:0] cfg_wait_limit,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              cmd_err,
   output logic [DATA_W-1:0] bus_din,
   output logic              stb_addr,
   output logic              stb_data,
   output logic              stb_rd,
   output logic              stb_wr,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_dout
);

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("phyctl_hs_master: ADDR_W must not exceed DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("phyctl_hs_master: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                   ack_s;
   logic                   expired;
   logic                   tmr_clr;
   logic                   tmr_run;
   logic [NUM_STROBES-1:0] stb;

   phyctl_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (1)
   ) u_ack_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bus_ack),
      .q_sync  (ack_s)
   );

   phyctl_wait_tmr #(
      .CNT_W (WAIT_W)
   ) u_wait_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .run     (tmr_run),
      .limit   (cfg_wait_limit),
      .expired (expired)
   );

   phyctl_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cmd_start),
      .is_write (cmd_write),
      .addr     (cmd_addr),
      .wdata    (cmd_wdata),
      .ack_s    (ack_s),
      .dout     (bus_dout),
      .expired  (expired),
      .din      (bus_din),
      .stb      (stb),
      .busy     (busy),
      .done     (done),
      .rd_data  (rd_data),
      .err      (cmd_err),
      .tmr_clr  (tmr_clr),
      .tmr_run  (tmr_run)
   );

   assign stb_addr = stb[STEP_ADDR];
   assign stb_data = stb[STEP_DATA];
   assign stb_rd   = stb[STEP_READ];
   assign stb_wr   = stb[STEP_WRITE];

   // R4
   data_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stb_data) |-> busy);

   // R8
   err_clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_start) && !$past(busy)) |-> !cmd_err);

   // R9
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy) |=> busy);

endmodule

// File: tb/phyctl_hs_master_bench.sv
module phyctl_hs_master_bench;

   localparam int CLK_P  = 10;
   localparam int AW     = 16;
   localparam int DW     = 16;
   localparam int WW     = 8;
   localparam int SYNC   = 3;
   localparam logic [DW-1:0] MUTE_VAL = 16'hDEAD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0;
   logic          cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic [WW-1:0] cfg_wait_limit = 8'd40;
   logic          busy, done, cmd_err;
   logic [DW-1:0] rd_data, bus_din;
   logic          stb_addr, stb_data, stb_rd, stb_wr;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_dout = '0;

   always #(CLK_P/2) clk = ~clk;

   phyctl_hs_master #(
      .ADDR_W (AW), .DATA_W (DW), .WAIT_W (WW), .SYNC_STAGES (SYNC)
   ) u_phyctl_hs_master (
      .clk (clk), .rst_n (rst_n),
      .cmd_start (cmd_start), .cmd_write (cmd_write),
      .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata),
      .cfg_wait_limit (cfg_wait_limit),
      .busy (busy), .done (done), .rd_data (rd_data), .cmd_err (cmd_err),
      .bus_din (bus_din), .stb_addr (stb_addr), .stb_data (stb_data),
      .stb_rd (stb_rd), .stb_wr (stb_wr),
      .bus_ack (bus_ack), .bus_dout (bus_dout)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int n_done = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      bit            is_wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [DW-1:0] exp_rd;
      bit            chk_rd;
      bit            chk_mem;
      bit            exp_err;
      int            exp_seq;
   } exp_item_t;

   exp_item_t exp_q[$];
   logic [DW-1:0] shadow [16];

   // PHY model state
   int            phy_mute = 0;
   int            phy_dly  = 1;
   bit            lat_chk  = 1;
   logic [DW-1:0] phy_mem [16];
   logic [DW-1:0] lat_addr = '0;
   logic [DW-1:0] lat_data = '0;
   int            seq_log  = 0;
   int            dly_cnt  = 0;
   bit            meas_on  = 0;
   int            meas     = 0;
   logic [3:0]    prev_stb = '0;

   // PHY model, acts on the falling edge
   initial begin
      for (int i = 0; i < 16; i++) phy_mem[i] = '0;
      forever begin
         logic [3:0] sv;
         @(negedge clk);
         sv = {stb_wr, stb_rd, stb_data, stb_addr};
         // R5
         check($countones(sv) <= 1, "R5", "strobes high together", sv, 0);
         if (sv != 4'b0 && prev_stb == 4'b0) begin
            for (int k = 0; k < 4; k++) if (sv[k]) seq_log = seq_log * 8 + k + 1;
         end
         if (meas_on) begin
            if (sv != 4'b0) meas++;
            else begin
               // R11 / R6
               if (lat_chk) check(meas == SYNC, "R11", "ack-to-strobe-fall edges", meas, SYNC);
               meas_on = 0;
            end
         end
         if (phy_mute != 0) begin
            bus_ack  = 1'b0;
            bus_dout = MUTE_VAL;
            dly_cnt  = 0;
         end else if (sv != 4'b0 && !bus_ack) begin
            dly_cnt++;
            if (dly_cnt >= phy_dly) begin
               dly_cnt = 0;
               bus_ack = 1'b1;
               meas_on = 1;
               meas    = 0;
               if (sv[0]) lat_addr = bus_din;
               if (sv[1]) lat_data = bus_din;
               if (sv[2]) bus_dout = phy_mem[lat_addr[3:0]];
               if (sv[3]) phy_mem[lat_addr[3:0]] = lat_data;
            end
         end else if (sv == 4'b0 && bus_ack) begin
            dly_cnt++;
            if (dly_cnt >= phy_dly) begin
               dly_cnt = 0;
               bus_ack = 1'b0;
            end
         end else begin
            dly_cnt = 0;
         end
         prev_stb = sv;
      end
   end

   // Monitor: pops expected items at each done pulse
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (rst_n && done) begin
            exp_item_t it;
            n_done++;
            // R9
            check(busy == 1'b1, "R9", "busy with done", busy, 1);
            if (exp_q.size() == 0) begin
               check(0, "R10", "unexpected done pulse", 1, 0);
            end else begin
               it = exp_q.pop_front();
               // R7 / R8
               check(cmd_err == it.exp_err, it.exp_err ? "R7" : "R8", "error flag", cmd_err, it.exp_err);
               // R2 / R4 strobe order
               check(seq_log == it.exp_seq, it.is_wr ? "R4" : "R3", "strobe order code", seq_log, it.exp_seq);
               if (it.chk_rd)
                  check(rd_data == it.exp_rd, "R3", "read data", rd_data, it.exp_rd);
               if (it.chk_mem)
                  check(phy_mem[it.addr[3:0]] == it.data, "R2", "write landed", phy_mem[it.addr[3:0]], it.data);
            end
            seq_log = 0;
            @(posedge clk);
            #(CLK_P/4);
            // R9
            check(!done && !busy, "R9", "done/busy after pulse", {done, busy}, 0);
         end
      end
   end

   task automatic pulse_start(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cmd_start = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_done(input int target);
      while (n_done < target) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit exp_err, input bit chk_mem);
      exp_item_t it;
      int tgt;
      it.is_wr = 1; it.addr = a; it.data = d; it.exp_rd = '0; it.chk_rd = 0;
      it.chk_mem = chk_mem; it.exp_err = exp_err; it.exp_seq = 84;
      exp_q.push_back(it);
      if (chk_mem) shadow[a[3:0]] = d;
      tgt = n_done + 1;
      pulse_start(1'b1, a, d);
      wait_done(tgt);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                          input bit exp_err);
      exp_item_t it;
      int tgt;
      it.is_wr = 0; it.addr = a; it.data = '0; it.exp_rd = exp_d; it.chk_rd = 1;
      it.chk_mem = 0; it.exp_err = exp_err; it.exp_seq = 11;
      exp_q.push_back(it);
      tgt = n_done + 1;
      pulse_start(1'b0, a, '0);
      wait_done(tgt);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !cmd_err, "R1", "status at reset", {busy, done, cmd_err}, 0);
      check({stb_addr, stb_data, stb_rd, stb_wr} == 4'b0, "R1", "strobes at reset",
            {stb_addr, stb_data, stb_rd, stb_wr}, 0);
      check(rd_data == '0, "R1", "read data at reset", rd_data, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R4: writes with several PHY delays
      phy_dly = 1; do_write(16'h1022, 16'hA5A5, 0, 1);
      phy_dly = 2; do_write(16'h1013, 16'h0F0F, 0, 1);
      phy_dly = 5; do_write(16'h0034, 16'h1234, 0, 1);
      // R3: reads back
      phy_dly = 1; do_read(16'h1022, shadow[2], 0);
      phy_dly = 4; do_read(16'h0034, shadow[4], 0);
      phy_dly = 2; do_read(16'h1013, shadow[3], 0);
      do_read(16'h0007, shadow[7], 0);

      // R10: second start while busy is ignored
      begin
         exp_item_t it;
         int tgt;
         it.is_wr = 1; it.addr = 16'h0045; it.data = 16'h4545; it.exp_rd = '0;
         it.chk_rd = 0; it.chk_mem = 1; it.exp_err = 0; it.exp_seq = 84;
         exp_q.push_back(it);
         shadow[5] = 16'h4545;
         tgt = n_done + 1;
         pulse_start(1'b1, 16'h0045, 16'h4545);
         repeat (3) @(negedge clk);
         pulse_start(1'b1, 16'h0046, 16'hBEEF);
         // R10
         check(busy == 1'b1, "R10", "still busy after ignored start", busy, 1);
         wait_done(tgt);
         repeat (20) @(negedge clk);
         check(n_done == tgt, "R10", "done pulse count", n_done, tgt);
         do_read(16'h0046, shadow[6], 0);
      end

      // R7: silent PHY, every wait runs out, command still ends
      lat_chk = 0;
      phy_mute = 1;
      do_read(16'h0011, MUTE_VAL, 1);
      do_write(16'h0018, 16'h7777, 1, 0);
      phy_mute = 0;
      repeat (10) @(negedge clk);

      // R8: error cleared by next good command
      lat_chk = 1;
      phy_dly = 1;
      do_read(16'h1022, shadow[2], 0);

      // R7: zero limit fails at once
      lat_chk = 0;
      cfg_wait_limit = 8'd0;
      do_write(16'h001F, 16'h5555, 1, 0);
      repeat (20) @(negedge clk);
      cfg_wait_limit = 8'd40;
      repeat (10) @(negedge clk);

      // R3 R8: normal operation again
      lat_chk = 1;
      do_read(16'h0034, shadow[4], 0);

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R9", "outstanding expected items", exp_q.size(), 0);
      finish_run();
   end

endmodule